// File: doc/BRIEF.md
# I2C Expander Port Read Sequencer

This block performs one complete single-byte read from an I2C port-expander device. It does not drive SCL or SDA itself. Instead it sends a fixed series of byte-level commands to a separate I2C master engine and waits for that engine to report that each command has finished. The series is: start condition, the address byte with the read bit set, one data byte read, the final acknowledge bit, and stop condition.

A one-cycle request strobe starts a transaction. The port select is captured with that strobe, and it picks which of two device addresses is used. When the transaction ends, the block presents a 16-bit result word and raises a one-cycle done pulse. On success the result holds the byte that was read. If a phase fails, the upper byte of the result tells which phase failed and the lower byte holds the engine's error code. A stop condition is sent in every case before the done pulse.

Top module: `exp_read_seq`

## Requirements
- R1: After reset, `done` is 0, `result` is 0x0000 and `cmd_valid` is 0.
- R2: A request received while idle starts a transaction whose first command is start. Commands appear on `cmd_op` with these codes: start=1, byte write=2, byte read=3, acknowledge bit=4, stop=5. `cmd_valid` is high for exactly one cycle per command. The next command is issued only after `eng_done` reports that the current one has finished.
- R3: The byte write command carries the address byte. This byte is 0x77 (0x76 plus the read bit 0x01) when the captured `port_sel` is 0. For any other value it is `ADDR_ALT` + 0x01, which is 0x41 by default.
- R4: When no phase fails, the command order is start, byte write, byte read, acknowledge bit, stop. The result is then {0x00, received byte}.
- R5: The acknowledge-bit command always has `cmd_bit` = 1. This sends a NACK, which ends the read.
- R6: If start completes with a nonzero `eng_err`, the next command is stop and the result is {0xFF, error code}.
- R7: If the address byte completes with a nonzero `eng_err` (for example a stretch timeout or a missing acknowledge), the next command is stop and the result is {0xFE, error code}.
- R8: If the byte read completes with a nonzero `eng_err`, the next command is stop and the result is {0xFC, error code}.
- R9: Error codes returned for the acknowledge-bit and stop commands do not change the result.
- R10: `done` is high for exactly one cycle. That cycle is the one right after the clock edge at which the stop command's `eng_done` is sampled. `result` is valid in that cycle and holds its value until the next done pulse.
- R11: A request received while a transaction is in progress is ignored. It issues no extra commands, does not change the address byte, and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe that starts a read |
| port_sel | input | PSEL_W | Port select, captured together with the request |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_byte | output | 8 | Byte for the byte write command |
| cmd_bit | output | 1 | Level to send for the acknowledge-bit command |
| eng_done | input | 1 | Engine has completed the current command |
| eng_err | input | 8 | Engine error code; 0 means success |
| eng_rxd | input | 8 | Byte received by the engine |
| result | output | 16 | Result word |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
If the phase register held a wrong value, the bench would see it within one command. The wrong code would appear on `cmd_op` in the same cycle as `cmd_valid`, or an error would not be followed directly by stop. A wrong failure tag or a lost received byte is visible only at the done pulse. A fault that publishes the result too late shows up in the idle cycles right after done, where the result must stay fixed. If the port capture were missing or the busy state leaked, a request made in the middle of a transaction would show up as a changed address byte or as an extra start after done.

// File: rtl/exp_rd_pkg.sv
package exp_rd_pkg;

    localparam int BYTE_W = 8;
    localparam int RES_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] DEV_ADDR_PRI = 8'h76;
    localparam logic [BYTE_W-1:0] RD_FLAG      = 8'h01;

    localparam logic [BYTE_W-1:0] TAG_OK    = 8'h00;
    localparam logic [BYTE_W-1:0] TAG_START = 8'hFF;
    localparam logic [BYTE_W-1:0] TAG_ADDR  = 8'hFE;
    localparam logic [BYTE_W-1:0] TAG_DATA  = 8'hFC;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_ACK   = 3'd4,
        OP_STOP  = 3'd5
    } bus_op_e;

    typedef enum logic [2:0] {
        PH_START,
        PH_ADDR,
        PH_DATA,
        PH_ACK,
        PH_STOP
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        bus_op_e           op;
        logic [BYTE_W-1:0] data;
        logic              bitv;
    } bus_cmd_t;

    function automatic bus_op_e phase_op(phase_e p);
        case (p)
            PH_START: return OP_START;
            PH_ADDR:  return OP_WRITE;
            PH_DATA:  return OP_READ;
            PH_ACK:   return OP_ACK;
            default:  return OP_STOP;
        endcase
    endfunction

    function automatic logic can_fail(phase_e p);
        return (p == PH_START) || (p == PH_ADDR) || (p == PH_DATA);
    endfunction

    function automatic phase_e next_phase(phase_e p, logic failed);
        if (failed && can_fail(p)) return PH_STOP;
        case (p)
            PH_START: return PH_ADDR;
            PH_ADDR:  return PH_DATA;
            PH_DATA:  return PH_ACK;
            default:  return PH_STOP;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] phase_tag(phase_e p);
        case (p)
            PH_START: return TAG_START;
            PH_ADDR:  return TAG_ADDR;
            PH_DATA:  return TAG_DATA;
            default:  return TAG_OK;
        endcase
    endfunction

    function automatic logic [RES_W-1:0] fold_code(logic [BYTE_W-1:0] tag,
                                                   logic [BYTE_W-1:0] low);
        return {tag, low};
    endfunction

endpackage

// File: rtl/exp_addr_map.sv
module exp_addr_map
    import exp_rd_pkg::*;
#(
    parameter int                PSEL_W   = 2,
    parameter logic [BYTE_W-1:0] ADDR_ALT = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PSEL_W-1:0] port_sel,
    output logic [BYTE_W-1:0] addr_byte
);
    logic [PSEL_W-1:0] sel_q;
    logic [BYTE_W-1:0] dev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (load) begin
            sel_q <= port_sel;
        end
    end

    always_comb begin
        dev_addr  = (sel_q == '0) ? DEV_ADDR_PRI : ADDR_ALT;
        addr_byte = dev_addr + RD_FLAG;
    end
endmodule

// File: rtl/exp_phase_ctl.sv
module exp_phase_ctl
    import exp_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_err,
    output phase_e            phase,
    output logic              issue,
    output logic              launch,
    output logic              step,
    output logic              fin
);
    seq_state_e state_q;
    phase_e     phase_q;
    logic       fin_q;

    always_comb begin
        launch = (state_q == ST_IDLE) && req;
        step   = (state_q == ST_WAIT) && eng_done;
        issue  = (state_q == ST_ISSUE);
        phase  = phase_q;
        fin    = fin_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_START;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        state_q <= ST_ISSUE;
                        phase_q <= PH_START;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (eng_done) begin
                        if (phase_q == PH_STOP) begin
                            state_q <= ST_IDLE;
                            fin_q   <= 1'b1;
                        end else begin
                            state_q <= ST_ISSUE;
                            phase_q <= next_phase(phase_q, eng_err != '0);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/exp_result_fold.sv
module exp_result_fold
    import exp_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              step,
    input  phase_e            phase,
    input  logic [BYTE_W-1:0] eng_err,
    input  logic [BYTE_W-1:0] eng_rxd,
    output logic [RES_W-1:0]  result
);
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] res_q;
    logic             failed;

    assign failed = (eng_err != '0) && can_fail(phase);
    assign result = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (launch) begin
                acc_q <= '0;
            end else if (step) begin
                if (failed) begin
                    acc_q <= fold_code(phase_tag(phase), eng_err);
                end else if (phase == PH_DATA) begin
                    acc_q <= fold_code(TAG_OK, eng_rxd);
                end
            end
            if (step && phase == PH_STOP) begin
                res_q <= acc_q;
            end
        end
    end
endmodule

// File: rtl/exp_read_seq.sv
module exp_read_seq
    import exp_rd_pkg::*;
#(
    parameter int                PSEL_W   = 2,
    parameter logic [BYTE_W-1:0] ADDR_ALT = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [PSEL_W-1:0] port_sel,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_bit,
    input  logic              eng_done,
    input  logic [7:0]        eng_err,
    input  logic [7:0]        eng_rxd,
    output logic [15:0]       result,
    output logic              done
);
    phase_e            phase;
    logic              issue;
    logic              launch;
    logic              step;
    logic              fin;
    logic [BYTE_W-1:0] addr_byte;
    bus_cmd_t          cmd;

    exp_phase_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .phase    (phase),
        .issue    (issue),
        .launch   (launch),
        .step     (step),
        .fin      (fin)
    );

    exp_addr_map #(
        .PSEL_W   (PSEL_W),
        .ADDR_ALT (ADDR_ALT)
    ) u_map (
        .clk       (clk),
        .rst       (rst),
        .load      (launch),
        .port_sel  (port_sel),
        .addr_byte (addr_byte)
    );

    exp_result_fold u_fold (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .step    (step),
        .phase   (phase),
        .eng_err (eng_err),
        .eng_rxd (eng_rxd),
        .result  (result)
    );

    always_comb begin
        cmd.op   = issue ? phase_op(phase) : OP_NONE;
        cmd.data = (phase == PH_ADDR) ? addr_byte : '0;
        cmd.bitv = (phase == PH_ACK);
    end

    assign cmd_valid = issue;
    assign cmd_op    = cmd.op;
    assign cmd_byte  = cmd.data;
    assign cmd_bit   = cmd.bitv;
    assign done      = fin;
endmodule

// File: rtl/exp_read_seq_chk.sv
module exp_read_seq_chk #(
    parameter logic [7:0] ADDR_ALT = 8'h40
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic [7:0]  cmd_byte,
    input logic        cmd_bit,
    input logic        eng_done,
    input logic [15:0] result,
    input logic        done
);
    logic [2:0] last_op;

    always_ff @(posedge clk) begin
        if (rst) last_op <= 3'd0;
        else if (cmd_valid) last_op <= cmd_op;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R5
    nack_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd4) |-> cmd_bit);

    // R3
    addr_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd2) |-> (cmd_byte == 8'h77 || cmd_byte == ADDR_ALT + 8'h01));

    // R10
    done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (last_op == 3'd5 && $past(eng_done)));

    // R6 R7 R8
    result_tag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (result[15:8] == 8'h00 || result[15:8] == 8'hFF ||
                  result[15:8] == 8'hFE || result[15:8] == 8'hFC));
endmodule

bind exp_read_seq exp_read_seq_chk #(.ADDR_ALT(ADDR_ALT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_bit   (cmd_bit),
    .eng_done  (eng_done),
    .result    (result),
    .done      (done)
);

// File: tb/exp_read_seq_test.sv
module exp_read_seq_test;
    localparam int         PSEL_W   = 2;
    localparam logic [7:0] ADDR_ALT = 8'h40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [PSEL_W-1:0] port_sel = '0;
    logic              eng_done = 1'b0;
    logic [7:0]        eng_err = 8'h00;
    logic [7:0]        eng_rxd = 8'h00;
    logic              cmd_valid;
    logic [2:0]        cmd_op;
    logic [7:0]        cmd_byte;
    logic              cmd_bit;
    logic [15:0]       result;
    logic              done;

    exp_read_seq #(.PSEL_W(PSEL_W), .ADDR_ALT(ADDR_ALT)) uut (
        .clk(clk), .rst(rst), .req(req), .port_sel(port_sel),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_bit(cmd_bit),
        .eng_done(eng_done), .eng_err(eng_err), .eng_rxd(eng_rxd),
        .result(result), .done(done)
    );

    always #10 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          exp_q[$];
    bit          exp_done_next = 0;
    bit          done_seen = 0;
    logic [15:0] exp_res = '0;
    logic [15:0] held_res = '0;
    int          cnt = 0;
    int          pend_op = 0;
    int          lat = 1;
    logic [7:0]  err_tab[0:7];
    logic [7:0]  rx_val = 8'h00;
    string       cur_tag = "R1";

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One clock of the engine model and the per-clock comparison.
    task automatic tick();
        int e;
        bit want_done;
        @(negedge clk);
        eng_done = 1'b0;
        eng_err  = 8'h00;
        req      = 1'b0;
        want_done = exp_done_next;
        exp_done_next = 0;
        if (want_done) begin
            check(done === 1'b1, "R10 done pulse", {15'd0, done}, 16'd1);
            check(result === exp_res, cur_tag, result, exp_res);
            done_seen = 1;
            held_res  = exp_res;
        end else if (done !== 1'b0) begin
            check(1'b0, "R10 unexpected done", {15'd0, done}, 16'd0);
        end
        if (cmd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 extra command", {13'd0, cmd_op}, 16'd0);
            end else begin
                e = exp_q.pop_front();
                check(int'(cmd_op) == e / 512, {cur_tag, " R2 op"}, {13'd0, cmd_op}, 16'(e / 512));
                if (e / 512 == 2)
                    check(cmd_byte === 8'(e % 256), "R3 address byte", {8'd0, cmd_byte}, 16'(e % 256));
                if (e / 512 == 4)
                    check(cmd_bit === 1'b1, "R5 nack bit", {15'd0, cmd_bit}, 16'd1);
                cnt = lat;
                pend_op = int'(cmd_op);
            end
        end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                eng_done = 1'b1;
                eng_err  = err_tab[pend_op];
                eng_rxd  = rx_val;
                if (pend_op == 5) exp_done_next = 1;
            end
        end
    endtask

    task automatic run(input logic [PSEL_W-1:0] ps, input logic [7:0] e_st, input logic [7:0] e_ad,
                       input logic [7:0] e_rd, input logic [7:0] e_ak, input logic [7:0] e_sp,
                       input logic [7:0] rx, input int l, input int busy_at, input string tag);
        logic [7:0] ab;
        ab = (ps == '0) ? 8'h77 : ADDR_ALT + 8'h01;
        exp_q.delete();
        exp_q.push_back(1 * 512);
        if (e_st != 0) begin
            exp_q.push_back(5 * 512);
            exp_res = {8'hFF, e_st};
        end else begin
            exp_q.push_back(2 * 512 + int'(ab));
            if (e_ad != 0) begin
                exp_q.push_back(5 * 512);
                exp_res = {8'hFE, e_ad};
            end else begin
                exp_q.push_back(3 * 512);
                if (e_rd != 0) begin
                    exp_q.push_back(5 * 512);
                    exp_res = {8'hFC, e_rd};
                end else begin
                    exp_q.push_back(4 * 512 + 256);
                    exp_q.push_back(5 * 512);
                    exp_res = {8'h00, rx};
                end
            end
        end
        err_tab[1] = e_st; err_tab[2] = e_ad; err_tab[3] = e_rd;
        err_tab[4] = e_ak; err_tab[5] = e_sp;
        rx_val = rx; lat = l; cur_tag = tag; done_seen = 0;
        tick();
        req = 1'b1;
        port_sel = ps;
        for (int i = 0; i < 400 && !done_seen; i++) begin
            tick();
            if (i == busy_at) begin
                req = 1'b1;
                port_sel = ~ps;
            end
        end
        if (!done_seen) check(1'b0, {tag, " R10 no done"}, 16'd0, 16'd1);
        for (int k = 0; k < 5; k++) begin
            tick();
            check(result === held_res, "R10 result held", result, held_res);
        end
        check(exp_q.size() == 0, {tag, " R4 sequence complete"}, 16'(exp_q.size()), 16'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int j = 0; j < 8; j++) err_tab[j] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R1 done after reset", {15'd0, done}, 16'd0);
        check(result === 16'h0000, "R1 result after reset", result, 16'h0000);
        check(cmd_valid === 1'b0, "R1 cmd_valid after reset", {15'd0, cmd_valid}, 16'd0);

        run(2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 1, -1, "R4 ok port0");
        run(2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 3, -1, "R3 ok port1");
        run(2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2, -1, "R4 ok zero byte");
        run(2'd0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h07, 8'h99, 2, -1, "R6 start fail");
        run(2'd1, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 8'h99, 1, -1, "R7 address fail");
        run(2'd0, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h11, 4, -1, "R8 read fail");
        run(2'd3, 8'h00, 8'h00, 8'h00, 8'h55, 8'h66, 8'hC3, 2, -1, "R9 ack stop errors ignored");
        run(2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 2, 1, "R11 busy request early");
        run(2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hE7, 2, 9, "R11 busy request late");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule